// File: doc/BRIEF.md
# Per-Block SRAM Privilege Filter

This block sits on the path from a single-cycle bus master to an on-chip synchronous SRAM. It divides the SRAM into equal blocks, and each block has one configuration bit. When the bit is set, only privileged transactions may use that block. When it is clear, any transaction may use it. The decision is made combinationally in the cycle the request is presented. A privileged request always goes through unchanged. An unprivileged request to a restricted block never reaches the memory. A blocked read or write fails silently: the read returns zeros and the write is lost. Only a blocked instruction fetch reports a bus error, and it does so on the response cycle.

The configuration bits sit in a small bank of 32-bit registers behind a separate register port. Only privileged accesses may write or read that port. After reset every block is restricted. Privileged software must therefore clear bits before unprivileged code can use any memory.

Top module: `sram_priv_filter`

## Requirements
- R1: After reset every configuration bit is 1: a privileged read of each configuration register returns 32'hFFFF_FFFF, and unprivileged accesses to any block are blocked.
- R2: The block index is address bits [15:9] (512-byte blocks). Block 32*k+n is controlled by bit n of configuration register k. An unprivileged access to a block whose bit is 0 is forwarded like a privileged one.
- R3: A privileged request is always forwarded (memory enable high, write enable equal to the request's write flag), whatever the configuration bit, and its read response carries the memory data.
- R4: An unprivileged read of a block whose bit is 1 does not enable the memory. It returns all-zero data on the response cycle and raises no bus error.
- R5: An unprivileged write to a block whose bit is 1 keeps the memory write enable low and raises no bus error.
- R6: An unprivileged instruction fetch (fetch flag 1, write flag 0) of a block whose bit is 1 raises the bus error output for exactly one cycle, the response cycle, with all-zero read data.
- R7: A configuration write takes effect only when the configuration port's privilege input is 1. Unprivileged writes leave the register unchanged.
- R8: An unprivileged read of a configuration register returns zero.
- R9: For a forwarded request, address and write data reach the memory unchanged in the request cycle, and the memory's read data appears on the bus one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_fetch | input | 1 | Read is an instruction fetch |
| bus_priv | input | 1 | Request is privileged |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, response cycle |
| bus_berr | output | 1 | Bus error, response cycle |
| mem_en | output | 1 | SRAM enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | 16 | SRAM byte address |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, one cycle after enable |
| cfg_sel | input | 1 | Configuration port access |
| cfg_we | input | 1 | Configuration write |
| cfg_priv | input | 1 | Configuration access is privileged |
| cfg_idx | input | 2 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |

## Verification
The bench first tries each kind of transaction against a fully restricted memory. Privileged reads, writes and fetches are then compared with unprivileged ones. This separates privilege bypass from the three distinct failure modes: a zeroed read, a dropped write, and a fetch that raises a bus error. Directed accesses land on both sides of block boundaries and on the last block. These show that the block index and register bit mapping are correct rather than off by one. Random mixes of configuration writes from both privilege levels and accesses with random flags follow, checked against a shadow copy of the bits. This exposes any write to the configuration bank that should have been ignored.

// File: rtl/sram_priv_pkg.sv
package sram_priv_pkg;
  localparam int unsigned SP_ADDR_W    = 16;
  localparam int unsigned SP_DATA_W    = 32;
  localparam int unsigned SP_BLK_BYTES = 512;
  localparam int unsigned SP_REG_W     = 32;

  typedef enum logic [1:0] {
    ACC_PASS    = 2'd0,
    ACC_DROP_WR = 2'd1,
    ACC_ZERO_RD = 2'd2,
    ACC_ERR_IF  = 2'd3
  } acc_verdict_e;
endpackage

// File: rtl/spf_cfg_bank.sv
module spf_cfg_bank #(
  parameter int unsigned NUM_REG = 4,
  parameter int unsigned REG_W   = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_REG),
  localparam int unsigned NUM_BLK = NUM_REG * REG_W,
  localparam int unsigned BLK_W  = $clog2(NUM_BLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             we,
  input  logic             priv,
  input  logic [IDX_W-1:0] idx,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic [BLK_W-1:0] blk_idx,
  output logic             blk_priv_only
);
  logic [REG_W-1:0]   bank_q [NUM_REG];
  logic [REG_W-1:0]   bank_d [NUM_REG];
  logic [NUM_REG-1:0] bank_en;
  logic [NUM_BLK-1:0] flat;
  logic               wr_ok;
  logic               rd_ok;

  always_comb begin
    wr_ok = sel & we & priv;
    rd_ok = sel & priv;
  end

  for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
    always_comb begin
      bank_en[k] = wr_ok && (idx == IDX_W'(k));
      bank_d[k]  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bank_q[k] <= '1;
      else if (bank_en[k]) bank_q[k] <= bank_d[k];
    end

    always_comb flat[k*REG_W +: REG_W] = bank_q[k];
  end

  always_comb begin
    blk_priv_only = flat[blk_idx];
    rdata         = rd_ok ? bank_q[idx] : '0;
  end

  // R7
  unpriv_cfg_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we && !priv) |=> $stable(flat));

  // R8
  unpriv_cfg_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !priv) |-> (rdata == '0));
endmodule

// File: rtl/spf_decide.sv
module spf_decide
  import sram_priv_pkg::*;
(
  input  logic         req,
  input  logic         we,
  input  logic         fetch,
  input  logic         priv,
  input  logic         priv_only,
  output logic         fwd_en,
  output logic         fwd_we,
  output logic         blocked,
  output logic         fetch_err,
  output acc_verdict_e verdict
);
  always_comb begin
    blocked   = req & ~priv & priv_only;
    fwd_en    = req & ~blocked;
    fwd_we    = fwd_en & we;
    fetch_err = blocked & ~we & fetch;
    if (!blocked)   verdict = ACC_PASS;
    else if (we)    verdict = ACC_DROP_WR;
    else if (fetch) verdict = ACC_ERR_IF;
    else            verdict = ACC_ZERO_RD;
  end
endmodule

// File: rtl/spf_resp.sv
module spf_resp
  import sram_priv_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_verdict_e      verdict,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_berr
);
  logic zero_q, zero_d;
  logic err_q,  err_d;

  always_comb begin
    zero_d = (verdict == ACC_ZERO_RD) || (verdict == ACC_ERR_IF);
    err_d  = (verdict == ACC_ERR_IF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      zero_q <= zero_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    bus_rdata = zero_q ? '0 : mem_rdata;
    bus_berr  = err_q;
  end

  // R6
  berr_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_berr |-> (bus_rdata == '0));

  // R6
  berr_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_berr |-> $past(verdict == ACC_ERR_IF));
endmodule

// File: rtl/sram_priv_filter.sv
module sram_priv_filter
  import sram_priv_pkg::*;
#(
  parameter int unsigned ADDR_W    = SP_ADDR_W,
  parameter int unsigned DATA_W    = SP_DATA_W,
  parameter int unsigned BLK_BYTES = SP_BLK_BYTES,
  parameter int unsigned REG_W     = SP_REG_W,
  localparam int unsigned OFS_W    = $clog2(BLK_BYTES),
  localparam int unsigned BLK_W    = ADDR_W - OFS_W,
  localparam int unsigned NUM_BLK  = 1 << BLK_W,
  localparam int unsigned NUM_REG  = NUM_BLK / REG_W,
  localparam int unsigned IDX_W    = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_fetch,
  input  logic              bus_priv,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_berr,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              cfg_sel,
  input  logic              cfg_we,
  input  logic              cfg_priv,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic [BLK_W-1:0] blk_idx;
  logic             priv_only;
  logic             blocked;
  logic             fetch_err;
  acc_verdict_e     verdict;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  always_comb begin
    rst_n_int = rst_sync_q[1];
    blk_idx   = bus_addr[ADDR_W-1 -: BLK_W];
    mem_addr  = bus_addr;
    mem_wdata = bus_wdata;
  end

  spf_cfg_bank #(.NUM_REG(NUM_REG), .REG_W(REG_W)) cfg_i (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .sel           (cfg_sel),
    .we            (cfg_we),
    .priv          (cfg_priv),
    .idx           (cfg_idx),
    .wdata         (cfg_wdata),
    .rdata         (cfg_rdata),
    .blk_idx       (blk_idx),
    .blk_priv_only (priv_only)
  );

  spf_decide dec_i (
    .req       (bus_req),
    .we        (bus_we),
    .fetch     (bus_fetch),
    .priv      (bus_priv),
    .priv_only (priv_only),
    .fwd_en    (mem_en),
    .fwd_we    (mem_we),
    .blocked   (blocked),
    .fetch_err (fetch_err),
    .verdict   (verdict)
  );

  spf_resp #(.DATA_W(DATA_W)) resp_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .verdict   (verdict),
    .mem_rdata (mem_rdata),
    .bus_rdata (bus_rdata),
    .bus_berr  (bus_berr)
  );

  // R3
  priv_passes_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_req && bus_priv) |-> (mem_en && (mem_we == bus_we)));

  // R5
  blocked_wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_req && bus_we && !bus_priv && priv_only) |-> !mem_we);

  // R4
  blocked_rd_no_en_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_req && !bus_we && !bus_priv && priv_only) |-> !mem_en);

  // R6
  fetch_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    fetch_err |-> (blocked && bus_fetch));
endmodule

// File: tb/sram_priv_filter_tb_top.sv
`timescale 1ns/1ps
module sram_priv_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we, bus_fetch, bus_priv;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_berr;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        cfg_sel, cfg_we, cfg_priv;
  logic [1:0]  cfg_idx;
  logic [31:0] cfg_wdata, cfg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] shadow [4];

  always #4 clk = ~clk;

  sram_priv_filter dut_i (.*);

  function automatic logic [31:0] pat(logic [15:0] a);
    return {a, ~a} ^ 32'h5A5A_0000;
  endfunction

  always_ff @(posedge clk) if (mem_en && !mem_we) mem_rdata <= pat(mem_addr);

  function automatic bit restricted(logic [15:0] a);
    logic [6:0] b;
    b = a[15:9];
    return shadow[b[6:5]][b[4:0]];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    bus_req = 0; bus_we = 0; bus_fetch = 0; bus_priv = 0;
    bus_addr = '0; bus_wdata = '0;
    cfg_sel = 0; cfg_we = 0; cfg_priv = 0; cfg_idx = '0; cfg_wdata = '0;
  endtask

  task automatic access(bit priv, bit we, bit fetch, logic [15:0] addr, logic [31:0] wd);
    bit    blk;
    string tag;
    blk = !priv && restricted(addr);
    if (blk) tag = we ? "R5" : (fetch ? "R6" : "R4");
    else     tag = priv ? "R3" : "R2";
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_fetch = fetch; bus_priv = priv;
    bus_addr = addr; bus_wdata = wd;
    #1;
    check({tag, " mem_en"}, 32'(mem_en), 32'(!blk));
    check({tag, " mem_we"}, 32'(mem_we), 32'(we && !blk));
    if (!blk) begin
      check("R9 mem_addr", 32'(mem_addr), 32'(addr));
      check("R9 mem_wdata", mem_wdata, wd);
    end
    @(negedge clk);
    idle();
    #1;
    if (!we) check({tag, " rdata"}, bus_rdata, blk ? 32'h0 : pat(addr));
    check({tag, " berr"}, 32'(bus_berr), 32'(blk && !we && fetch));
    @(negedge clk);
    #1;
    check("R6 berr one cycle", 32'(bus_berr), 32'h0);
  endtask

  task automatic cfg_write(bit priv, logic [1:0] idx, logic [31:0] d);
    @(negedge clk);
    cfg_sel = 1; cfg_we = 1; cfg_priv = priv; cfg_idx = idx; cfg_wdata = d;
    if (priv) shadow[idx] = d;
    @(negedge clk);
    idle();
  endtask

  task automatic cfg_read(bit priv, logic [1:0] idx, string tag);
    @(negedge clk);
    cfg_sel = 1; cfg_we = 0; cfg_priv = priv; cfg_idx = idx;
    #1;
    check(tag, cfg_rdata, priv ? shadow[idx] : 32'h0);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4; k++) shadow[k] = 32'hFFFF_FFFF;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < 4; k++) cfg_read(1, 2'(k), "R1 reset cfg");
    access(0, 0, 0, 16'h0000, 0);             // R1 all blocked at reset
    access(0, 0, 0, 16'hFFFC, 0);             // R1 last block
    access(1, 0, 0, 16'h1234, 0);             // R3 priv read
    access(1, 1, 0, 16'h2000, 32'hCAFE_F00D); // R3 priv write
    access(1, 0, 1, 16'h0400, 0);             // R3 priv fetch
    access(0, 1, 0, 16'h0800, 32'h1111_2222); // R5
    access(0, 0, 1, 16'h0C00, 0);             // R6
    access(0, 0, 1, 16'h0C04, 0);             // R6 again

    cfg_write(0, 2'd0, 32'h0);                // R7 unpriv write ignored
    cfg_read(1, 2'd0, "R7 cfg after unpriv write");
    access(0, 0, 0, 16'h0000, 0);             // R7 still blocked
    cfg_read(0, 2'd1, "R8 unpriv cfg read");

    cfg_write(1, 2'd0, 32'hFFFF_FFF7);        // R2 open block 3
    access(0, 0, 0, 16'h05FC, 0);             // R2 block 2 still restricted
    access(0, 0, 0, 16'h0600, 0);             // R2 block 3 open
    access(0, 1, 0, 16'h07FC, 32'hA5A5_0001); // R2/R9 write forwarded
    access(0, 0, 0, 16'h0800, 0);             // R2 block 4 restricted
    cfg_write(1, 2'd3, 32'h7FFF_FFFF);        // R2 open block 127
    access(0, 0, 1, 16'hFE00, 0);             // R2 fetch allowed
    access(0, 0, 1, 16'hFDFC, 0);             // R6 block 126
    cfg_read(1, 2'd3, "R7 priv cfg write");

    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom % 8;
      if (r == 0) cfg_write($urandom % 2, 2'($urandom), $urandom);
      else if (r == 1) cfg_read($urandom % 2, 2'($urandom), "R7/R8 random cfg read");
      else begin
        bit we;
        we = ($urandom % 3) == 0;
        access($urandom % 2, we, !we && ($urandom % 2), 16'($urandom & 32'hFFFC), $urandom);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule